// File: doc/BRIEF.md
# EDO DRAM Initialization and Refresh Sequencer

This block owns the RAS, CAS and WE strobes of an asynchronous EDO page-mode DRAM through power-up initialization and refresh. All strobe timing is counted in system clock cycles.

After reset it keeps the strobes quiet for a power-up pause. It then issues a fixed number of CAS-before-RAS (CBR) cycles and raises `ready`. In normal operation it issues CBR refresh in one of two styles, selected by `refresh_burst`:
- **Distributed:** one row every `REF_PERIOD_CYC/ROWS` cycles.
- **Burst:** all `ROWS` rows back-to-back once per `REF_PERIOD_CYC`.

A host that wants the memory raises `host_req`. While `host_gnt` is high, the host's own strobes are passed straight through. A refresh that comes due while the host is granted waits until the host lets go. The host is then held off until that refresh is complete.

A level request `sr_req` puts the DRAM into self refresh and brings it out again. The refresh work added around self refresh depends on the style:
- **Distributed:** entry is immediate, and one CBR follows exit.
- **Burst:** a full set of `ROWS` CBRs precedes entry, and another full set follows exit. This burst treatment is also the correct one for a system that refreshes with RAS-only cycles.

The states and their transitions are:
- PAUSE → INIT when the pause timer expires.
- INIT → IDLE after the last initialization CBR.
- IDLE → REF when a refresh is pending. Otherwise IDLE → SR_PRE (burst style) or SR_ENTER (distributed style) on `sr_req`. Otherwise IDLE → HOST on `host_req`.
- HOST → IDLE when `host_req` drops.
- REF → IDLE after its batch of CBRs.
- SR_PRE → SR_ENTER after the full pre-entry set.
- SR_ENTER → SELF after the CAS setup time.
- SELF → SR_EXIT when `sr_req` drops.
- SR_EXIT → SR_POST after the precharge time.
- SR_POST → IDLE after the post-exit CBRs.

Top module: `edo_refresh_seq`

## Requirements
- R1: From reset release, RAS and CAS stay high for `PAUSE_CYC+1` cycles. CAS first goes low in cycle `PAUSE_CYC+2`. In reset, all strobes are high and `ready` and `host_gnt` are low.
- R2: After the pause, exactly `INIT_CYC` CBR cycles are issued. `ready` rises in the cycle after the last one's precharge and then stays high.
- R3: Every CBR cycle has the same shape:
  - one cycle with both strobes high;
  - `CAS_SETUP_CYC` cycles with CAS low and RAS high;
  - `RAS_LOW_CYC` cycles with both low;
  - `RAS_PRE_CYC` cycles with both high.

  Outside a grant, RAS never falls unless CAS was already low.
- R4: Whenever `host_gnt` is low, `dram_we_n` is high.
- R5: With `refresh_burst`=0, one CBR is made pending every `REF_PERIOD_CYC/ROWS` counted cycles. Counted cycles are those spent in IDLE, HOST or REF.
- R6: With `refresh_burst`=1, a pending refresh runs `ROWS` CBR cycles back-to-back. A refresh becomes pending every `REF_PERIOD_CYC` counted cycles.
- R7: In IDLE the priority is: pending refresh first, then `sr_req`, then `host_req`.
  - `host_gnt` rises one cycle after `host_req` is seen in IDLE, and drops one cycle after `host_req` is low.
  - While granted, the three DRAM strobes equal `host_ras_n`, `host_cas_n` and `host_we_n`.
  - Without a grant, the host inputs have no effect on the strobes.
- R8: In distributed style, `sr_req` leads straight to self refresh. CAS is low with RAS high for `CAS_SETUP_CYC` cycles. Then both strobes stay low for as long as `sr_req` stays high.
- R9: In burst style, `ROWS` CBR cycles are issued immediately before self-refresh entry.
- R10: After `sr_req` drops, both strobes are high for `RAS_PRE_CYC` cycles. The sequencer then issues one CBR (distributed style) or `ROWS` CBRs (burst style) before returning to IDLE.
- R11: The refresh interval count restarts from zero whenever the sequencer leaves IDLE, HOST and REF. A refresh that is already pending is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_burst | input | 1 | Refresh style: 0 selects distributed, 1 selects burst |
| sr_req | input | 1 | Level request to hold the DRAM in self refresh |
| host_req | input | 1 | Host request for the strobes |
| host_ras_n | input | 1 | Host RAS, passed through while granted |
| host_cas_n | input | 1 | Host CAS, passed through while granted |
| host_we_n | input | 1 | Host WE, passed through while granted |
| host_gnt | output | 1 | Host owns the strobes |
| ready | output | 1 | Initialization complete |
| dram_ras_n | output | 1 | DRAM row strobe |
| dram_cas_n | output | 1 | DRAM column strobe |
| dram_we_n | output | 1 | DRAM write enable |

## Verification
The ordering check takes for granted that the host, once granted, is itself responsible for its strobes. For that reason, RAS falls are judged only in cycles where neither the current nor the previous cycle was granted.

The sequencer assumes that `refresh_burst` changes only while the DRAM sits in self refresh. At that point the interval counter is cleared, so a change of limit cannot strand the counter above its new limit. The stimulus therefore switches style only in the middle of a self-refresh period, and the exit that follows uses the new style.

Host requests and self-refresh requests are held as levels for many cycles. Strobe patterns are applied only while `host_req` is high.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_INIT,
        ST_IDLE,
        ST_HOST,
        ST_REF,
        ST_SR_PRE,
        ST_SR_ENTER,
        ST_SELF,
        ST_SR_EXIT,
        ST_SR_POST
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACT,
        PH_PRE
    } cbr_phase_t;

endpackage

// File: rtl/edo_cbr_engine.sv
module edo_cbr_engine
    import edo_seq_pkg::*;
#(
    parameter int unsigned CAS_SETUP_CYC = 2,
    parameter int unsigned RAS_LOW_CYC   = 15,
    parameter int unsigned RAS_PRE_CYC   = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output cbr_phase_t phase,
    output logic       done
);
    localparam int unsigned CW = $clog2(CAS_SETUP_CYC + RAS_LOW_CYC + RAS_PRE_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SETUP;
                        cnt   <= CW'(CAS_SETUP_CYC - 1);
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_ACT;
                        cnt   <= CW'(RAS_LOW_CYC - 1);
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                PH_ACT: begin
                    if (cnt == '0) begin
                        phase <= PH_PRE;
                        cnt   <= CW'(RAS_PRE_CYC - 1);
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                PH_PRE: begin
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign done = (phase == PH_PRE) && (cnt == '0);

endmodule

// File: rtl/edo_tick_gen.sv
module edo_tick_gen #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [TW-1:0] limit,
    output logic          tick
);
    logic [TW-1:0] cnt;

    assign tick = en && (cnt == limit - TW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + TW'(1);
        end
    end

endmodule

// File: rtl/edo_refresh_seq.sv
module edo_refresh_seq
    import edo_seq_pkg::*;
#(
    parameter int unsigned PAUSE_CYC      = 50000,
    parameter int unsigned INIT_CYC       = 8,
    parameter int unsigned ROWS           = 1024,
    parameter int unsigned REF_PERIOD_CYC = 16000000,
    parameter int unsigned CAS_SETUP_CYC  = 2,
    parameter int unsigned RAS_LOW_CYC    = 15,
    parameter int unsigned RAS_PRE_CYC    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic refresh_burst,
    input  logic sr_req,
    input  logic host_req,
    input  logic host_ras_n,
    input  logic host_cas_n,
    input  logic host_we_n,
    output logic host_gnt,
    output logic ready,
    output logic dram_ras_n,
    output logic dram_cas_n,
    output logic dram_we_n
);
    localparam int unsigned DIST_CYC = REF_PERIOD_CYC / ROWS;
    localparam int unsigned TW = $clog2(REF_PERIOD_CYC + 1);
    localparam int unsigned RW = $clog2(ROWS + INIT_CYC + 1);
    localparam int unsigned MW = $clog2(PAUSE_CYC + CAS_SETUP_CYC + RAS_PRE_CYC + 1);

    seq_state_t    state;
    cbr_phase_t    phase;
    logic [MW-1:0] tmr;
    logic [RW-1:0] rem;
    logic          pend;
    logic          tick;
    logic          tick_en;
    logic          batch;
    logic          cbr_start;
    logic          cbr_done;
    logic [TW-1:0] tick_limit;

    assign batch     = (state == ST_INIT) || (state == ST_REF) ||
                       (state == ST_SR_PRE) || (state == ST_SR_POST);
    assign cbr_start = batch && (phase == PH_IDLE);
    assign tick_en   = (state == ST_IDLE) || (state == ST_HOST) || (state == ST_REF);
    assign tick_limit = refresh_burst ? TW'(REF_PERIOD_CYC) : TW'(DIST_CYC);

    edo_cbr_engine #(
        .CAS_SETUP_CYC(CAS_SETUP_CYC),
        .RAS_LOW_CYC  (RAS_LOW_CYC),
        .RAS_PRE_CYC  (RAS_PRE_CYC)
    ) u_cbr (
        .clk  (clk),
        .rst_n(rst_n),
        .start(cbr_start),
        .phase(phase),
        .done (cbr_done)
    );

    edo_tick_gen #(
        .TW(TW)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (tick_en),
        .limit(tick_limit),
        .tick (tick)
    );

    // State register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PAUSE;
            tmr   <= MW'(PAUSE_CYC - 1);
            rem   <= '0;
            ready <= 1'b0;
            pend  <= 1'b0;
        end else begin
            if (tick) begin
                pend <= 1'b1;
            end else if (state == ST_IDLE && pend) begin
                pend <= 1'b0;
            end
            unique case (state)
                ST_PAUSE: begin
                    if (tmr == '0) begin
                        state <= ST_INIT;
                        rem   <= RW'(INIT_CYC);
                    end else begin
                        tmr <= tmr - MW'(1);
                    end
                end
                ST_INIT: begin
                    if (cbr_done) begin
                        if (rem == RW'(1)) begin
                            state <= ST_IDLE;
                            ready <= 1'b1;
                        end
                        rem <= rem - RW'(1);
                    end
                end
                ST_IDLE: begin
                    if (pend) begin
                        state <= ST_REF;
                        rem   <= refresh_burst ? RW'(ROWS) : RW'(1);
                    end else if (sr_req) begin
                        if (refresh_burst) begin
                            state <= ST_SR_PRE;
                            rem   <= RW'(ROWS);
                        end else begin
                            state <= ST_SR_ENTER;
                            tmr   <= MW'(CAS_SETUP_CYC - 1);
                        end
                    end else if (host_req) begin
                        state <= ST_HOST;
                    end
                end
                ST_HOST: begin
                    if (!host_req) begin
                        state <= ST_IDLE;
                    end
                end
                ST_REF: begin
                    if (cbr_done) begin
                        if (rem == RW'(1)) begin
                            state <= ST_IDLE;
                        end
                        rem <= rem - RW'(1);
                    end
                end
                ST_SR_PRE: begin
                    if (cbr_done) begin
                        if (rem == RW'(1)) begin
                            state <= ST_SR_ENTER;
                            tmr   <= MW'(CAS_SETUP_CYC - 1);
                        end
                        rem <= rem - RW'(1);
                    end
                end
                ST_SR_ENTER: begin
                    if (tmr == '0) begin
                        state <= ST_SELF;
                    end else begin
                        tmr <= tmr - MW'(1);
                    end
                end
                ST_SELF: begin
                    if (!sr_req) begin
                        state <= ST_SR_EXIT;
                        tmr   <= MW'(RAS_PRE_CYC - 1);
                    end
                end
                ST_SR_EXIT: begin
                    if (tmr == '0) begin
                        state <= ST_SR_POST;
                        rem   <= refresh_burst ? RW'(ROWS) : RW'(1);
                    end else begin
                        tmr <= tmr - MW'(1);
                    end
                end
                ST_SR_POST: begin
                    if (cbr_done) begin
                        if (rem == RW'(1)) begin
                            state <= ST_IDLE;
                        end
                        rem <= rem - RW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Strobe outputs
    always_comb begin
        dram_ras_n = 1'b1;
        dram_cas_n = 1'b1;
        dram_we_n  = 1'b1;
        host_gnt   = 1'b0;
        unique case (state)
            ST_HOST: begin
                host_gnt   = 1'b1;
                dram_ras_n = host_ras_n;
                dram_cas_n = host_cas_n;
                dram_we_n  = host_we_n;
            end
            ST_SR_ENTER: begin
                dram_cas_n = 1'b0;
            end
            ST_SELF: begin
                dram_cas_n = 1'b0;
                dram_ras_n = 1'b0;
            end
            ST_INIT, ST_REF, ST_SR_PRE, ST_SR_POST: begin
                dram_ras_n = (phase != PH_ACT);
                dram_cas_n = !((phase == PH_SETUP) || (phase == PH_ACT));
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/edo_refresh_seq_chk.sv
module edo_refresh_seq_chk #(
    parameter int unsigned PAUSE_CYC = 50000,
    parameter int unsigned INIT_CYC  = 8
) (
    input logic clk,
    input logic rst_n,
    input logic host_req,
    input logic host_gnt,
    input logic ready,
    input logic dram_ras_n,
    input logic dram_cas_n,
    input logic dram_we_n
);
    localparam int unsigned CW = $clog2(PAUSE_CYC + 2);
    localparam int unsigned FW = $clog2(INIT_CYC + 2);

    logic [CW-1:0] cyc;
    logic [FW-1:0] falls;
    logic          prev_ras;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc      <= '0;
            falls    <= '0;
            prev_ras <= 1'b1;
        end else begin
            prev_ras <= dram_ras_n;
            if (cyc != CW'(PAUSE_CYC)) begin
                cyc <= cyc + CW'(1);
            end
            if (!ready && prev_ras && !dram_ras_n && falls != FW'(INIT_CYC + 1)) begin
                falls <= falls + FW'(1);
            end
        end
    end

    a_r1_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc < CW'(PAUSE_CYC)) |-> (dram_ras_n && dram_cas_n));

    a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    a_r2_init_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (falls == FW'(INIT_CYC)));

    a_r3_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_gnt && !$past(host_gnt) && $fell(dram_ras_n)) |-> $past(!dram_cas_n));

    a_r4_we_high: assert property (@(posedge clk) disable iff (!rst_n)
        !host_gnt |-> dram_we_n);

    a_r7_grant_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_gnt) |-> ($past(host_req) && ready));

    a_r7_grant_release: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt && !host_req) |=> !host_gnt);

endmodule

bind edo_refresh_seq edo_refresh_seq_chk #(
    .PAUSE_CYC(PAUSE_CYC),
    .INIT_CYC (INIT_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_req  (host_req),
    .host_gnt  (host_gnt),
    .ready     (ready),
    .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n),
    .dram_we_n (dram_we_n)
);

// File: tb/edo_refresh_seq_test.sv
module edo_refresh_seq_test;
    localparam int PAUSE = 100;
    localparam int INIT  = 8;
    localparam int ROWS  = 16;
    localparam int REFP  = 640;
    localparam int DIST  = REFP / ROWS;
    localparam int S     = 1;
    localparam int L     = 3;
    localparam int P     = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tb_burst = 1'b0;
    logic tb_sr = 1'b0;
    logic tb_host = 1'b0;
    logic h_ras = 1'b1, h_cas = 1'b1, h_we = 1'b1;
    logic host_gnt, ready, dram_ras_n, dram_cas_n, dram_we_n;

    always #2 clk = ~clk;

    edo_refresh_seq #(
        .PAUSE_CYC(PAUSE), .INIT_CYC(INIT), .ROWS(ROWS), .REF_PERIOD_CYC(REFP),
        .CAS_SETUP_CYC(S), .RAS_LOW_CYC(L), .RAS_PRE_CYC(P)
    ) uut (
        .clk(clk), .rst_n(rst_n), .refresh_burst(tb_burst), .sr_req(tb_sr),
        .host_req(tb_host), .host_ras_n(h_ras), .host_cas_n(h_cas), .host_we_n(h_we),
        .host_gnt(host_gnt), .ready(ready), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state
    bit    e_ras = 1, e_cas = 1, e_rdy = 0, e_host = 0;
    string e_tag = "R1";
    int    tcnt = 0;
    bit    pend = 0, m_tick = 0, after_sr = 0, p_snap = 0;
    int    win = 0;
    int    ncyc = 0;
    int    first_fall = 0;
    bit    prev_cas = 1;

    // Per-cycle compare, away from the active edge
    always @(negedge clk) begin
        logic [4:0] act, exp;
        if (rst_n) ncyc++;
        act = {dram_ras_n, dram_cas_n, dram_we_n, ready, host_gnt};
        exp = e_host ? {h_ras, h_cas, h_we, e_rdy, 1'b1} : {e_ras, e_cas, 1'b1, e_rdy, 1'b0};
        chk(act == exp, rst_n ? e_tag : "R1 reset", int'(act), int'(exp));
        if (prev_cas && !dram_cas_n) win++;
        if (rst_n && first_fall == 0 && !dram_cas_n) first_fall = ncyc;
        prev_cas = dram_cas_n;
    end

    task automatic m_cyc(input bit r, input bit c, input bit en, input bit host, input string tag);
        e_ras = r; e_cas = c; e_host = host; e_tag = tag;
        @(posedge clk);
        m_tick = 0;
        if (en) begin
            if (tcnt == (tb_burst ? REFP : DIST) - 1) begin
                tcnt = 0; pend = 1; m_tick = 1;
            end else begin
                tcnt++;
            end
        end else begin
            tcnt = 0;
        end
    endtask

    task automatic m_batch(input int n, input bit en, input string tag);
        for (int i = 0; i < n; i++) begin
            m_cyc(1, 1, en, 0, tag);
            repeat (S) m_cyc(1, 0, en, 0, tag);
            repeat (L) m_cyc(0, 0, en, 0, tag);
            repeat (P) m_cyc(1, 1, en, 0, tag);
        end
    endtask

    // Behavioural reference model
    initial begin
        wait (rst_n == 1'b1);
        repeat (PAUSE) m_cyc(1, 1, 0, 0, "R1");
        win = 0;
        m_batch(INIT, 0, "R2,R3");
        chk(win == INIT, "R2 init CBR count", win, INIT);
        chk(first_fall == PAUSE + 2, "R1 first CAS fall cycle", first_fall, PAUSE + 2);
        e_rdy = 1;
        forever begin
            p_snap = pend;
            m_cyc(1, 1, 1, 0, "R4,R7");
            if (p_snap) begin
                if (!m_tick) pend = 0;
                m_batch(tb_burst ? ROWS : 1, 1,
                        after_sr ? "R3,R11" : (tb_burst ? "R3,R6" : "R3,R5"));
                after_sr = 0;
            end else if (tb_sr) begin
                if (tb_burst) begin
                    win = 0;
                    m_batch(ROWS, 0, "R3,R9");
                    chk(win == ROWS, "R9 pre-entry CBR count", win, ROWS);
                end
                repeat (S) m_cyc(1, 0, 0, 0, "R8");
                forever begin
                    m_cyc(0, 0, 0, 0, "R8");
                    if (!tb_sr) break;
                end
                repeat (P) m_cyc(1, 1, 0, 0, "R10");
                begin
                    int n;
                    n = tb_burst ? ROWS : 1;
                    win = 0;
                    m_batch(n, 0, "R3,R10");
                    chk(win == n, "R10 post-exit CBR count", win, n);
                end
                after_sr = 1;
            end else if (tb_host) begin
                forever begin
                    m_cyc(0, 0, 1, 1, "R4,R7");
                    if (!tb_host) break;
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic host_access(input int n);
        tb_host = 1'b1;
        for (int k = 0; k < n; k++) begin
            h_ras = k[1]; h_cas = k[0]; h_we = k[2];
            step(1);
        end
        tb_host = 1'b0; h_ras = 1'b1; h_cas = 1'b1; h_we = 1'b1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1-all act=hung exp=done");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // host strobes toggle before ready: must not reach the DRAM (R7)
        h_ras = 1'b0; h_cas = 1'b0; h_we = 1'b0;
        step(20);
        h_ras = 1'b1; h_cas = 1'b1; h_we = 1'b1;
        while (!ready) step(1);
        // distributed refresh while idle (R5)
        step(200);
        // host accesses spanning refresh ticks (R7)
        host_access(30);
        step(5);
        host_access(55);
        step(3);
        // toggling host strobes without a request (R7)
        h_ras = 1'b0; h_cas = 1'b0; h_we = 1'b0;
        step(10);
        h_ras = 1'b1; h_cas = 1'b1; h_we = 1'b1;
        // distributed self refresh (R8, R10)
        tb_sr = 1'b1;
        step(50);
        tb_sr = 1'b0;
        step(60);
        // self refresh entered distributed, style switched while inside (R10, R11)
        tb_sr = 1'b1;
        step(20);
        tb_burst = 1'b1;
        step(20);
        tb_sr = 1'b0;
        step(200);
        // burst refresh with host traffic (R6, R7)
        step(700);
        host_access(40);
        step(600);
        // burst self refresh (R9, R10)
        tb_sr = 1'b1;
        step(200);
        tb_sr = 1'b0;
        step(300);
        finish_run();
    end

endmodule